// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO Manager

This block keeps 64 independent circular FIFOs inside one shared word memory. Each queue is described by a 32-bit configuration word. The word holds the live write and read pointers, a base address in 16-word units, an entry-size code, a buffer-size code and two 3-bit watermark thresholds. A client pushes or pops one entry on a queue named by its ID through a command port. A multi-word entry moves one memory word per cycle. When the transfer ends, the block answers with a single-cycle response.

Every queue carries flags that are recomputed from its pointers: empty, nearly empty, nearly full and full. The first 32 queues (the lower group) expose all four flags, together with sticky underflow and overflow bits. The other 32 queues (the upper group) expose only nearly empty and full, one bit per queue. Software sets up a queue by writing its configuration word. It reads the word back, with live pointers, on the same port.

Top module: `qm_top`

## Requirements
- R1: After reset, each lower-queue status nibble is 0x3, the upper nearly-empty vector is all ones, the upper full vector is all zeros, all sticky bits are 0, `cmdReady` is 1 and every configuration word reads 0.
- R2: Pushes and pops of one-word entries on a queue return the data in first-in first-out order. Each accepted command produces exactly one response that lasts one cycle.
- R3: The entry-size code in config bits [23:22] selects the words per entry: 0 selects 1, 1 selects 2, and 2 or 3 select 4. Entry word i travels in `cmdData`/`rspData` bits [32*i+31:32*i]. Unused response words read 0. The pointer advances by the entry's word count.
- R4: The buffer-size code in config bits [25:24] selects 16 << code words. Pointers wrap modulo the buffer size. A queue holds exactly buffer/entry entries before it reports full.
- R5: The configuration word has the write pointer in [6:0], the read pointer in [13:7], the base in [21:14], the entry code in [23:22], the buffer code in [25:24], the nearly-empty threshold in [28:26] and the nearly-full threshold in [31:29]. `cfgRData` returns the word for `cfgQid` with the live pointers in it. A configuration write also clears the queue's internal wrap bits.
- R6: Lower queue q reports its flags in `statLow` bits [4q+3:4q]. Bit 0 is empty, bit 1 nearly empty, bit 2 nearly full and bit 3 full.
- R7: Nearly empty is 1 when the occupancy in entries is at most the nearly-empty threshold. Nearly full is 1 when the free space in entries is at most the nearly-full threshold.
- R8: A pop from an empty queue returns all-zero data with `rspErr`=1 and leaves both pointers unchanged. For a lower queue it also sets the sticky underflow bit.
- R9: A push to a full queue is dropped with `rspErr`=1. For a lower queue it also sets the sticky overflow bit.
- R10: For lower queue q, sticky underflow is `statUo` bit 2q and sticky overflow is bit 2q+1. A 1 on the matching `errClr` bit clears the sticky bit.
- R11: Upper queue q (32 to 63) reports nearly empty in `statUpNe` bit q-32 and full in `statUpFull` bit q-32. Its errors set no sticky bit.
- R12: Queues with distinct base addresses hold their data independently, even when commands to them are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgQid | input | 6 | Queue selected for configuration write and readback |
| cfgWData | input | 32 | Configuration word to write |
| cfgRData | output | 32 | Configuration word of `cfgQid`, with live pointers |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Block idle and able to accept a command |
| cmdPush | input | 1 | 1 for a push, 0 for a pop |
| cmdQid | input | 6 | Target queue |
| cmdData | input | 128 | Entry to push, word i in bits [32i+31:32i] |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Command rejected (underflow or overflow) |
| rspData | output | 128 | Popped entry |
| errClr | input | 64 | Write-one-to-clear for the sticky bits |
| statLow | output | 128 | Four flags per lower queue |
| statUo | output | 64 | Underflow/overflow pair per lower queue |
| statUpNe | output | 32 | Nearly-empty flag per upper queue |
| statUpFull | output | 32 | Full flag per upper queue |

## Verification
The bench fills a 16-entry queue to capacity and then keeps going. A design that confuses full with empty when the pointers meet would accept the 17th push or lose all sixteen entries. The bench then pops and pushes across the wrap point to catch a pointer that fails to wrap modulo the buffer size. It pops an empty queue and reads the configuration word back, which exposes a design that moves the read pointer or returns stale data on underflow. Multi-word entries of two and four words check word ordering, zeroing of unused response words, and watermarks counted in entries rather than in words. Upper-group queues check that their errors never leak into the lower sticky vector.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int WORD_W   = 32;
  localparam int MAX_EW   = 4;
  localparam int EIDX_W   = $clog2(MAX_EW);
  localparam int CFG_W    = 32;
  localparam int PTR_W    = 7;

  typedef struct packed {
    logic             accept;
    logic             memWe;
    logic             capWord;
    logic             advWr;
    logic             advRd;
    logic             setUnder;
    logic             setOver;
    logic [EIDX_W-1:0] wordIdx;
  } qmStrobe_t;

  function automatic logic [7:0] sizeWords(input logic [1:0] code);
    return 8'd16 << code;
  endfunction

  function automatic logic [1:0] entryShift(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
#(
  parameter int QID_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdPush,
  input  logic [QID_W-1:0] cmdQid,
  input  logic             selEmpty,
  input  logic             selFull,
  input  logic [2:0]       selEntryWords,
  output logic             cmdReady,
  output logic [QID_W-1:0] selQid,
  output logic             curPush,
  output qmStrobe_t        strobe,
  output logic             rspValid,
  output logic             rspErr
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} ctrlState_t;

  ctrlState_t            state;
  logic [QID_W-1:0]      curQid;
  logic [EIDX_W-1:0]     wordCnt;
  logic                  errQ;
  logic                  lastWord;

  assign cmdReady = (state == S_IDLE);
  assign selQid   = (state == S_IDLE) ? cmdQid : curQid;
  assign rspValid = (state == S_DONE);
  assign rspErr   = errQ;
  assign lastWord = ({1'b0, wordCnt} == (selEntryWords - 3'd1));

  always_comb begin
    strobe = '0;
    strobe.wordIdx = wordCnt;
    case (state)
      S_IDLE: if (cmdValid) begin
        strobe.accept   = 1'b1;
        strobe.setOver  = cmdPush && selFull;
        strobe.setUnder = !cmdPush && selEmpty;
      end
      S_XFER: begin
        strobe.memWe   = curPush;
        strobe.capWord = !curPush;
        strobe.advWr   = curPush && lastWord;
        strobe.advRd   = !curPush && lastWord;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curQid  <= '0;
      curPush <= 1'b0;
      wordCnt <= '0;
      errQ    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          curQid  <= cmdQid;
          curPush <= cmdPush;
          wordCnt <= '0;
          if ((cmdPush && selFull) || (!cmdPush && selEmpty)) begin
            errQ  <= 1'b1;
            state <= S_DONE;
          end else begin
            errQ  <= 1'b0;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          if (lastWord) state <= S_DONE;
          else          wordCnt <= wordCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REJECT_UNDER: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdValid && !cmdPush && selEmpty) |=> (rspValid && rspErr)); // R8
  AST_REJECT_OVER: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdValid && cmdPush && selFull) |=> (rspValid && rspErr)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R2
endmodule

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int NUM_LOW = 32,
  parameter int MEM_AW  = 10,
  localparam int QID_W  = $clog2(NUM_Q),
  localparam int NUM_UP = NUM_Q - NUM_LOW,
  localparam int ENT_W  = WORD_W * MAX_EW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qmStrobe_t            strobe,
  input  logic [QID_W-1:0]     selQid,
  input  logic                 curPush,
  input  logic [ENT_W-1:0]     cmdData,
  input  logic                 cfgWe,
  input  logic [QID_W-1:0]     cfgQid,
  input  logic [CFG_W-1:0]     cfgWData,
  output logic [CFG_W-1:0]     cfgRData,
  input  logic [2*NUM_LOW-1:0] errClr,
  output logic                 selEmpty,
  output logic                 selFull,
  output logic [2:0]           selEntryWords,
  output logic [ENT_W-1:0]     rspData,
  output logic [4*NUM_LOW-1:0] statLow,
  output logic [2*NUM_LOW-1:0] statUo,
  output logic [NUM_UP-1:0]    statUpNe,
  output logic [NUM_UP-1:0]    statUpFull
);
  localparam int MEM_WORDS = 1 << MEM_AW;

  logic [CFG_W-1:0]  cfgQ  [NUM_Q];
  logic [NUM_Q-1:0]  wrapW, wrapR;
  logic [WORD_W-1:0] mem   [MEM_WORDS];
  logic [ENT_W-1:0]  pushBuf, rdBuf;
  logic [2*NUM_LOW-1:0] uoQ, uoSet;
  logic [NUM_Q-1:0]  emptyV, nearEmptyV, nearFullV, fullV;

  // Per-queue flag generation
  for (genvar q = 0; q < NUM_Q; q++) begin : g_flag
    logic [CFG_W-1:0] c;
    logic [7:0] sz, occW, occE, freeE;
    logic [1:0] sh;
    assign c     = cfgQ[q];
    assign sz    = sizeWords(c[25:24]);
    assign sh    = entryShift(c[23:22]);
    assign occW  = (wrapW[q] == wrapR[q]) ? ({1'b0, c[6:0]} - {1'b0, c[13:7]})
                                          : ({1'b0, c[6:0]} + sz - {1'b0, c[13:7]});
    assign occE  = occW >> sh;
    assign freeE = (sz >> sh) - occE;
    assign emptyV[q]     = (occW == 8'd0);
    assign fullV[q]      = (occW == sz);
    assign nearEmptyV[q] = (occE <= {5'd0, c[28:26]});
    assign nearFullV[q]  = (freeE <= {5'd0, c[31:29]});
    if (q < NUM_LOW) begin : g_low
      assign statLow[4*q +: 4] = {fullV[q], nearFullV[q], nearEmptyV[q], emptyV[q]};
    end else begin : g_up
      assign statUpNe[q-NUM_LOW]   = nearEmptyV[q];
      assign statUpFull[q-NUM_LOW] = fullV[q];
    end
  end

  // Selected-queue decode and addressing
  logic [CFG_W-1:0]  selCfg;
  logic [7:0]        selSize, ptrSum, ptrNext, wordOff;
  logic [PTR_W-1:0]  ptrCur;
  logic              ptrWraps;
  logic [MEM_AW-1:0] memAddr;

  assign selCfg        = cfgQ[selQid];
  assign selSize       = sizeWords(selCfg[25:24]);
  assign selEntryWords = 3'd1 << entryShift(selCfg[23:22]);
  assign selEmpty      = emptyV[selQid];
  assign selFull       = fullV[selQid];
  assign ptrCur        = curPush ? selCfg[6:0] : selCfg[13:7];
  assign wordOff       = ({1'b0, ptrCur} + {{(8-EIDX_W){1'b0}}, strobe.wordIdx}) & (selSize - 8'd1);
  assign memAddr       = MEM_AW'({selCfg[21:14], 4'b0000}) + MEM_AW'(wordOff);
  assign ptrSum        = {1'b0, ptrCur} + {5'd0, selEntryWords};
  assign ptrWraps      = (ptrSum >= selSize);
  assign ptrNext       = ptrWraps ? (ptrSum - selSize) : ptrSum;
  assign cfgRData      = cfgQ[cfgQid];
  assign rspData       = rdBuf;
  assign statUo        = uoQ;

  always_comb begin
    uoSet = '0;
    for (int i = 0; i < NUM_LOW; i++) begin
      if (int'(selQid) == i) begin
        uoSet[2*i]   = strobe.setUnder;
        uoSet[2*i+1] = strobe.setOver;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_Q; i++) cfgQ[i] <= '0;
      wrapW   <= '0;
      wrapR   <= '0;
      uoQ     <= '0;
      pushBuf <= '0;
      rdBuf   <= '0;
    end else begin
      uoQ <= (uoQ & ~errClr) | uoSet;
      if (strobe.accept) begin
        pushBuf <= cmdData;
        rdBuf   <= '0;
      end
      if (strobe.capWord) rdBuf[WORD_W*strobe.wordIdx +: WORD_W] <= mem[memAddr];
      if (strobe.advWr) begin
        cfgQ[selQid][6:0] <= ptrNext[PTR_W-1:0];
        wrapW[selQid]     <= wrapW[selQid] ^ ptrWraps;
      end
      if (strobe.advRd) begin
        cfgQ[selQid][13:7] <= ptrNext[PTR_W-1:0];
        wrapR[selQid]      <= wrapR[selQid] ^ ptrWraps;
      end
      if (cfgWe) begin
        cfgQ[cfgQid]  <= cfgWData;
        wrapW[cfgQid] <= 1'b0;
        wrapR[cfgQid] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[memAddr] <= pushBuf[WORD_W*strobe.wordIdx +: WORD_W];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advWr |-> !selFull); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advRd |-> !selEmpty); // R8
  AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setUnder && int'(selQid) < NUM_LOW) |=> (statUo != '0)); // R10
endmodule

// File: rtl/qm_top.sv
module qm_top
  import qm_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int NUM_LOW = 32,
  parameter int MEM_AW  = 10,
  localparam int QID_W  = $clog2(NUM_Q),
  localparam int NUM_UP = NUM_Q - NUM_LOW,
  localparam int ENT_W  = WORD_W * MAX_EW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [QID_W-1:0]     cfgQid,
  input  logic [CFG_W-1:0]     cfgWData,
  output logic [CFG_W-1:0]     cfgRData,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic                 cmdPush,
  input  logic [QID_W-1:0]     cmdQid,
  input  logic [ENT_W-1:0]     cmdData,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [ENT_W-1:0]     rspData,
  input  logic [2*NUM_LOW-1:0] errClr,
  output logic [4*NUM_LOW-1:0] statLow,
  output logic [2*NUM_LOW-1:0] statUo,
  output logic [NUM_UP-1:0]    statUpNe,
  output logic [NUM_UP-1:0]    statUpFull
);
  qmStrobe_t        strobe;
  logic [QID_W-1:0] selQid;
  logic             curPush, selEmpty, selFull;
  logic [2:0]       selEntryWords;

  qm_ctrl #(.QID_W(QID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPush(cmdPush), .cmdQid(cmdQid),
    .selEmpty(selEmpty), .selFull(selFull), .selEntryWords(selEntryWords),
    .cmdReady(cmdReady), .selQid(selQid), .curPush(curPush), .strobe(strobe),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  qm_datapath #(.NUM_Q(NUM_Q), .NUM_LOW(NUM_LOW), .MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selQid(selQid), .curPush(curPush),
    .cmdData(cmdData), .cfgWe(cfgWe), .cfgQid(cfgQid), .cfgWData(cfgWData),
    .cfgRData(cfgRData), .errClr(errClr), .selEmpty(selEmpty), .selFull(selFull),
    .selEntryWords(selEntryWords), .rspData(rspData), .statLow(statLow),
    .statUo(statUo), .statUpNe(statUpNe), .statUpFull(statUpFull)
  );
endmodule

// File: tb/qm_top_tb.sv
`timescale 1ns/1ps
module qm_top_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWe = 1'b0;
  logic [5:0]   cfgQid = '0;
  logic [31:0]  cfgWData = '0;
  logic [31:0]  cfgRData;
  logic         cmdValid = 1'b0, cmdReady, cmdPush = 1'b0;
  logic [5:0]   cmdQid = '0;
  logic [127:0] cmdData = '0;
  logic         rspValid, rspErr;
  logic [127:0] rspData;
  logic [63:0]  errClr = '0;
  logic [127:0] statLow;
  logic [63:0]  statUo;
  logic [31:0]  statUpNe, statUpFull;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qm_top u_dut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input logic [7:0] base, input logic [1:0] es,
      input logic [1:0] bs, input logic [2:0] ne, input logic [2:0] nf);
    return {nf, ne, bs, es, base, 14'd0};
  endfunction

  task automatic cfgWrite(input logic [5:0] q, input logic [31:0] w);
    @(negedge clk); cfgWe = 1; cfgQid = q; cfgWData = w;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic cfgRead(input logic [5:0] q, output logic [31:0] w);
    @(negedge clk); cfgQid = q; #1 w = cfgRData;
  endtask

  task automatic doCmd(input logic push, input logic [5:0] q, input logic [127:0] d,
      output logic [127:0] r, output logic err);
    @(negedge clk); cmdValid = 1; cmdPush = push; cmdQid = q; cmdData = d;
    @(negedge clk); cmdValid = 0;
    for (int n = 0; n < 20 && !rspValid; n++) @(negedge clk);
    r = rspData; err = rspErr;
  endtask

  task automatic clrPulse(input logic [63:0] m);
    @(negedge clk); errClr = m;
    @(negedge clk); errClr = '0;
  endtask

  task automatic tReset();
    logic [31:0] w;
    chk("R1 statLow", statLow, {32{4'h3}});
    chk("R1 upNe", statUpNe, 32'hFFFF_FFFF);
    chk("R1 upFull", statUpFull, 0);
    chk("R1 uo", statUo, 0);
    chk("R1 ready", cmdReady, 1);
    cfgRead(6'd9, w);
    chk("R1 cfg", w, 0);
  endtask

  task automatic tFifo();
    logic [127:0] r; logic e; logic [31:0] w;
    cfgWrite(3, mkCfg(8'd1, 2'd0, 2'd0, 3'd2, 3'd1));
    doCmd(1, 3, 128'hA1, r, e);
    chk("R6 R7 nib after 1", statLow[12 +: 4], 4'h2);
    doCmd(1, 3, 128'hB2, r, e);
    doCmd(1, 3, 128'hC3, r, e);
    chk("R7 nib after 3", statLow[12 +: 4], 4'h0);
    doCmd(0, 3, 0, r, e); chk("R2 pop1", r, 128'hA1);
    doCmd(0, 3, 0, r, e); chk("R2 pop2", r, 128'hB2);
    doCmd(0, 3, 0, r, e); chk("R2 pop3", r, 128'hC3);
    chk("R2 err", e, 0);
    chk("R6 empty nib", statLow[12 +: 4], 4'h3);
    cfgRead(3, w);
    chk("R5 cfg ptrs", w, mkCfg(8'd1, 2'd0, 2'd0, 3'd2, 3'd1) | 32'd3 | (32'd3 << 7));
  endtask

  task automatic tFullWrap();
    logic [127:0] r; logic e; logic [31:0] w;
    cfgWrite(5, mkCfg(8'd2, 2'd0, 2'd0, 3'd0, 3'd0));
    for (int i = 0; i < 16; i++) doCmd(1, 5, 128'(i + 16'h500), r, e);
    chk("R4 full nib", statLow[20 +: 4], 4'hC);
    doCmd(1, 5, 128'hDEAD, r, e);
    chk("R9 over err", e, 1);
    chk("R10 over bit", statUo, 64'h1 << 11);
    doCmd(0, 5, 0, r, e); chk("R4 pop first", r, 128'h500);
    doCmd(1, 5, 128'h777, r, e); chk("R4 wrap push ok", e, 0);
    for (int i = 1; i < 16; i++) begin
      doCmd(0, 5, 0, r, e);
      if (i == 1 || i == 15) chk("R4 wrap order", r, 128'(i + 16'h500));
    end
    doCmd(0, 5, 0, r, e); chk("R4 wrapped entry", r, 128'h777);
    chk("R6 empty again", statLow[20 +: 4], 4'h3);
    clrPulse(64'h1 << 11);
    chk("R10 clear over", statUo, 0);
    doCmd(0, 5, 0, r, e);
    chk("R8 under err", e, 1);
    chk("R8 under data", r, 0);
    chk("R10 under bit", statUo, 64'h1 << 10);
    cfgRead(5, w);
    chk("R8 ptrs unchanged", w[13:0], {7'd1, 7'd1});
    clrPulse(64'h1 << 10);
    chk("R10 clear under", statUo, 0);
  endtask

  task automatic tMultiWord();
    logic [127:0] r; logic e; logic [31:0] w;
    cfgWrite(7, mkCfg(8'd4, 2'd2, 2'd1, 3'd1, 3'd1));
    doCmd(1, 7, {32'h13, 32'h12, 32'h11, 32'h10}, r, e);
    cfgRead(7, w);
    chk("R3 wr step 4", w[6:0], 7'd4);
    chk("R7 ne entries", statLow[28 +: 4], 4'h2);
    doCmd(1, 7, {32'h23, 32'h22, 32'h21, 32'h20}, r, e);
    chk("R7 two entries", statLow[28 +: 4], 4'h0);
    doCmd(0, 7, 0, r, e);
    chk("R3 four-word pop", r, {32'h13, 32'h12, 32'h11, 32'h10});
    cfgWrite(8, mkCfg(8'd6, 2'd1, 2'd0, 3'd0, 3'd7));
    doCmd(1, 8, {32'hFF, 32'hEE, 32'hB, 32'hA}, r, e);
    chk("R7 nf entries", statLow[32 +: 4], 4'h4);
    doCmd(0, 8, 0, r, e);
    chk("R3 two-word pop", r, {64'd0, 32'hB, 32'hA});
  endtask

  task automatic tUpper();
    logic [127:0] r; logic e;
    cfgWrite(40, mkCfg(8'd8, 2'd0, 2'd0, 3'd0, 3'd0));
    doCmd(1, 40, 128'h40, r, e);
    chk("R11 ne low", statUpNe[8], 0);
    doCmd(0, 40, 0, r, e);
    chk("R11 ne high", statUpNe[8], 1);
    doCmd(0, 40, 0, r, e);
    chk("R11 upper under err", e, 1);
    chk("R11 no sticky", statUo, 0);
    for (int i = 0; i < 16; i++) doCmd(1, 40, 128'(i), r, e);
    chk("R11 full bit", statUpFull, 32'h1 << 8);
  endtask

  task automatic tIsolation();
    logic [127:0] r; logic e;
    doCmd(1, 3, 128'h3333, r, e);
    doCmd(1, 5, 128'h5555, r, e);
    doCmd(0, 3, 0, r, e); chk("R12 q3", r, 128'h3333);
    doCmd(0, 5, 0, r, e); chk("R12 q5", r, 128'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tFifo();
    tFullWrap();
    tMultiWord();
    tUpper();
    tIsolation();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule